// File: doc/BRIEF.md
# Text Mode Glyph Fetch Unit

This unit sits between video memory and the pixel shifter of a character display. For each character byte fetched from video memory it produces one 8-pixel horizontal slice of that character's glyph. The line of the 8-by-16 glyph cell is chosen from the low bits of the scan line counter. The top bit of each character byte is a per-character inverse flag, and a programmable cursor position inverts the cell it covers. The two inversions combine by exclusive-or, so a highlighted character under the cursor shows normally.

The font is an internal read-only table with a registered read. Every output is aligned to that single cycle of latency: the slice, its valid flag and a mark flag that reports whether the slice was inverted. With text mode off, the byte goes unchanged through the same pipeline stage, so the shifter sees a fixed latency in either mode. The screen is 64 cells wide. It is 30 cell rows tall, or 25 rows in the short layout, and scan lines below the last row produce blank slices.

Top module: `txt_glyph_unit`

## Requirements
- R1: After reset, pixValid, pixOut and markOut are 0. The cursor sits at column 0, row 31, which is outside every layout, so no cell is inverted until the cursor is written.
- R2: When byteValid is sampled high on a clock edge, pixValid is high after that edge. When byteValid is low, pixValid is low after the edge. Latency is exactly one cycle.
- R3: When textEn is low, pixOut equals the sampled charByte and markOut is 0.
- R4: When textEn is high, the font line is selected by code = charByte[6:0] and line = rowCount[3:0]. The test font holds the value {line ^ {1'b0, code[6:4]}, code[3:0]} (upper nibble, lower nibble).
- R5: When charByte[7] is 1 in text mode, pixOut is the bitwise complement of the font line.
- R6: The cell row is rowCount[8:4]. If the cell row is at least 30 (shortMode=0) or at least 25 (shortMode=1), a text-mode slice is 0 and markOut is 0.
- R7: A cycle with cursorWe high loads cursorCol (6 bits) and cursorRow (5 bits). A text-mode byte whose colIdx and cell row equal the cursor is output inverted, and no other cell is affected.
- R8: markOut equals charByte[7] XOR the cursor match for visible text cells. When both are set, the slice is not inverted.
- R9: While pixValid is low, pixOut and markOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| textEn | input | 1 | 1 selects glyph lookup, 0 selects byte pass-through |
| shortMode | input | 1 | 1 selects the 25-row layout, 0 the 30-row layout |
| byteValid | input | 1 | A character byte is presented this cycle |
| charByte | input | 8 | Byte from video memory: inverse flag in bit 7, code in bits 6:0 |
| rowCount | input | 9 | Scan line counter; bits 3:0 give the glyph line, bits 8:4 the cell row |
| colIdx | input | 6 | Cell column of the presented byte |
| cursorWe | input | 1 | Load the cursor position |
| cursorCol | input | 6 | New cursor column |
| cursorRow | input | 5 | New cursor row |
| pixValid | output | 1 | Slice on pixOut is valid |
| pixOut | output | 8 | Glyph slice or passed-through byte |
| markOut | output | 1 | Slice was inverted (inverse flag XOR cursor) |

## Verification
The bench builds the unit with its defaults: 64 columns, a 16-line cell, 128 codes, and 30 and 25 row limits. With these values, rows 25 through 29 are blank in the short layout and visible in the tall one, so both limits are checked on the same scan lines. With a 16-line cell, the full 9-bit line counter reaches row 30 and above, so the blanking boundary is exercised. The 6-bit column lets the cursor be placed at the last column, 63, which covers the end of the compare range.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  // Strobes handed from control to datapath, aligned to the output stage
  typedef struct packed {
    logic valid;   // a byte was sampled last cycle
    logic text;    // glyph lookup instead of pass-through
    logic blank;   // cell row outside the active layout
    logic flip;    // inverse flag XOR cursor match
  } stage_t;
endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int CELL_H     = 16,
  parameter int ROW_BITS   = 9,
  parameter int ROWS_TALL  = 30,
  parameter int ROWS_SHORT = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic textEn,
  input  logic shortMode,
  input  logic byteValid,
  input  logic invFlag,
  input  logic [ROW_BITS-1:0] rowCount,
  input  logic [$clog2(COLS)-1:0] colIdx,
  input  logic cursorWe,
  input  logic [$clog2(COLS)-1:0] cursorCol,
  input  logic [ROW_BITS-$clog2(CELL_H)-1:0] cursorRow,
  output stage_t stg
);
  localparam int LINE_BITS = $clog2(CELL_H);
  localparam int COL_BITS  = $clog2(COLS);
  localparam int TROW_BITS = ROW_BITS - LINE_BITS;

  logic [COL_BITS-1:0]  curCol;
  logic [TROW_BITS-1:0] curRow;
  logic [TROW_BITS-1:0] cellRow;
  logic [TROW_BITS:0]   rowLimit;
  logic cursorHit, outside;

  assign cellRow   = rowCount[ROW_BITS-1:LINE_BITS];
  assign rowLimit  = shortMode ? (TROW_BITS+1)'(ROWS_SHORT) : (TROW_BITS+1)'(ROWS_TALL);
  assign outside   = {1'b0, cellRow} >= rowLimit;
  assign cursorHit = (colIdx == curCol) && (cellRow == curRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCol <= '0;
      curRow <= '1;
    end else if (cursorWe) begin
      curCol <= cursorCol;
      curRow <= cursorRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg.valid <= byteValid;
      stg.text  <= byteValid & textEn;
      stg.blank <= byteValid & textEn & outside;
      stg.flip  <= byteValid & textEn & ~outside & (invFlag ^ cursorHit);
    end
  end
endmodule

// File: rtl/glyph_data.sv
module glyph_data
  import glyph_pkg::*;
#(
  parameter int CELL_W    = 8,
  parameter int CELL_H    = 16,
  parameter int CODE_BITS = 7,
  parameter int ROW_BITS  = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic byteValid,
  input  logic [CELL_W-1:0] charByte,
  input  logic [ROW_BITS-1:0] rowCount,
  input  stage_t stg,
  output logic [CELL_W-1:0] pixOut,
  output logic markOut
);
  localparam int LINE_BITS = $clog2(CELL_H);
  localparam int ADDR_BITS = CODE_BITS + LINE_BITS;
  localparam int DEPTH     = 1 << ADDR_BITS;

  // Test font: upper nibble = line ^ code[6:4], lower nibble = code[3:0]
  function automatic logic [CELL_W-1:0] fontLine(input int idx);
    logic [CODE_BITS-1:0] code;
    logic [LINE_BITS-1:0] line;
    logic [CELL_W-1:0] v;
    code = CODE_BITS'(idx >> LINE_BITS);
    line = LINE_BITS'(idx);
    v = '0;
    v[3:0] = code[3:0];
    v[7:4] = 4'(line) ^ {1'b0, code[6:4]};
    return v;
  endfunction

  logic [CELL_W-1:0] fontRom [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign fontRom[g] = fontLine(g);
  end

  logic [ADDR_BITS-1:0] romAddr;
  logic [CELL_W-1:0] romQ, byteQ;

  assign romAddr = {charByte[CODE_BITS-1:0], rowCount[LINE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romQ  <= '0;
      byteQ <= '0;
    end else if (byteValid) begin
      romQ  <= fontRom[romAddr];
      byteQ <= charByte;
    end
  end

  always_comb begin
    if (!stg.valid)      pixOut = '0;
    else if (!stg.text)  pixOut = byteQ;
    else if (stg.blank)  pixOut = '0;
    else                 pixOut = romQ ^ {CELL_W{stg.flip}};
  end
  assign markOut = stg.flip;
endmodule

// File: rtl/txt_glyph_unit.sv
module txt_glyph_unit
  import glyph_pkg::*;
#(
  parameter int COLS       = 64,
  parameter int CELL_W     = 8,
  parameter int CELL_H     = 16,
  parameter int CODE_BITS  = 7,
  parameter int ROW_BITS   = 9,
  parameter int ROWS_TALL  = 30,
  parameter int ROWS_SHORT = 25
) (
  input  logic clk,
  input  logic rstN,
  input  logic textEn,
  input  logic shortMode,
  input  logic byteValid,
  input  logic [CELL_W-1:0] charByte,
  input  logic [ROW_BITS-1:0] rowCount,
  input  logic [$clog2(COLS)-1:0] colIdx,
  input  logic cursorWe,
  input  logic [$clog2(COLS)-1:0] cursorCol,
  input  logic [ROW_BITS-$clog2(CELL_H)-1:0] cursorRow,
  output logic pixValid,
  output logic [CELL_W-1:0] pixOut,
  output logic markOut
);
  stage_t stg;

  glyph_ctrl #(
    .COLS(COLS), .CELL_H(CELL_H), .ROW_BITS(ROW_BITS),
    .ROWS_TALL(ROWS_TALL), .ROWS_SHORT(ROWS_SHORT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .textEn(textEn), .shortMode(shortMode),
    .byteValid(byteValid), .invFlag(charByte[CELL_W-1]),
    .rowCount(rowCount), .colIdx(colIdx), .cursorWe(cursorWe),
    .cursorCol(cursorCol), .cursorRow(cursorRow), .stg(stg)
  );

  glyph_data #(
    .CELL_W(CELL_W), .CELL_H(CELL_H), .CODE_BITS(CODE_BITS), .ROW_BITS(ROW_BITS)
  ) i_data (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .charByte(charByte),
    .rowCount(rowCount), .stg(stg), .pixOut(pixOut), .markOut(markOut)
  );

  assign pixValid = stg.valid;
endmodule

// File: rtl/txt_glyph_unit_chk.sv
module txt_glyph_unit_chk (
  input logic clk,
  input logic rstN,
  input logic textEn,
  input logic shortMode,
  input logic byteValid,
  input logic [7:0] charByte,
  input logic [8:0] rowCount,
  input logic pixValid,
  input logic [7:0] pixOut,
  input logic markOut
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> pixValid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> !pixValid);
  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !textEn) |=> (pixOut == $past(charByte) && !markOut));
  // R6
  blank_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && textEn && shortMode && rowCount[8:4] >= 5'd25) |=> (pixOut == 8'h00 && !markOut));
  // R6
  blank_tall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && textEn && !shortMode && rowCount[8:4] >= 5'd30) |=> (pixOut == 8'h00 && !markOut));
  // R9
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> (pixOut == 8'h00 && !markOut));
endmodule

bind txt_glyph_unit txt_glyph_unit_chk i_chk (
  .clk(clk), .rstN(rstN), .textEn(textEn), .shortMode(shortMode),
  .byteValid(byteValid), .charByte(charByte), .rowCount(rowCount),
  .pixValid(pixValid), .pixOut(pixOut), .markOut(markOut)
);

// File: tb/test_txt_glyph_unit.sv
`timescale 1ns/1ps
module test_txt_glyph_unit;
  logic clk = 0;
  logic rstN = 0;
  logic textEn = 0, shortMode = 0, byteValid = 0, cursorWe = 0;
  logic [7:0] charByte = '0;
  logic [8:0] rowCount = '0;
  logic [5:0] colIdx = '0, cursorCol = '0;
  logic [4:0] cursorRow = '0;
  logic pixValid, markOut;
  logic [7:0] pixOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txt_glyph_unit i_txt_glyph_unit (
    .clk(clk), .rstN(rstN), .textEn(textEn), .shortMode(shortMode),
    .byteValid(byteValid), .charByte(charByte), .rowCount(rowCount),
    .colIdx(colIdx), .cursorWe(cursorWe), .cursorCol(cursorCol),
    .cursorRow(cursorRow), .pixValid(pixValid), .pixOut(pixOut), .markOut(markOut)
  );

  function automatic logic [7:0] fontOf(input logic [6:0] c, input logic [3:0] l);
    return {l ^ {1'b0, c[6:4]}, c[3:0]};
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got valid/mark/pix=%h expected %h", tag, got, exp);
    end
  endtask

  // present one byte, sample the aligned result one cycle later
  task automatic present(input logic txt, input logic sh, input logic [7:0] b,
                         input logic [8:0] row, input logic [5:0] col);
    @(negedge clk);
    textEn = txt; shortMode = sh; charByte = b; rowCount = row; colIdx = col;
    byteValid = 1;
    @(negedge clk);
    byteValid = 0;
  endtask

  task automatic setCursor(input logic [5:0] c, input logic [4:0] r);
    @(negedge clk);
    cursorWe = 1; cursorCol = c; cursorRow = r;
    @(negedge clk);
    cursorWe = 0;
  endtask

  task automatic testReset();
    check("R1 reset outputs", {pixValid, markOut, pixOut}, 10'h0);
    present(1, 0, 8'h00, 9'h1F0, 6'd0); // row 31 col 0 -> blank anyway
    check("R1 reset cursor off-screen", {pixValid, markOut, pixOut}, {2'b10, 8'h00});
    present(1, 0, 8'h00, 9'h000, 6'd0); // row 0 col 0 must not be inverted
    check("R1 reset cursor not at row 0", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h00, 4'h0)});
  endtask

  task automatic testIdle();
    @(negedge clk);
    check("R9 idle", {pixValid, markOut, pixOut}, 10'h0);
    check("R2 no valid without byte", {9'h0, pixValid}, 10'h0);
  endtask

  task automatic testPass();
    present(0, 0, 8'hA5, 9'h013, 6'd3);
    check("R3 pass-through A5", {pixValid, markOut, pixOut}, {2'b10, 8'hA5});
    present(0, 1, 8'hFF, 9'h1F0, 6'd9);
    check("R3 pass-through ignores row limit", {pixValid, markOut, pixOut}, {2'b10, 8'hFF});
  endtask

  task automatic testGlyph();
    present(1, 0, 8'h41, 9'h005, 6'd10);
    check("R4 glyph 41 line 5", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h41, 4'h5)});
    present(1, 0, 8'h7F, 9'h03F, 6'd11);
    check("R4 glyph 7F line 15", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h7F, 4'hF)});
    present(1, 1, 8'h2C, 9'h18A, 6'd12); // row 24 short: visible
    check("R6 short last row visible", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h2C, 4'hA)});
  endtask

  task automatic testInverse();
    present(1, 0, 8'hC1, 9'h005, 6'd10);
    check("R5 inverse flag", {pixValid, markOut, pixOut}, {2'b11, ~fontOf(7'h41, 4'h5)});
  endtask

  task automatic testRows();
    present(1, 1, 8'h33, 9'h190, 6'd1); // row 25 short
    check("R6 short row 25 blank", {pixValid, markOut, pixOut}, {2'b10, 8'h00});
    present(1, 0, 8'h33, 9'h192, 6'd1); // row 25 tall: visible
    check("R6 tall row 25 visible", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h33, 4'h2)});
    present(1, 0, 8'hB3, 9'h1E0, 6'd1); // row 30 tall, inverse set
    check("R6 tall row 30 blank", {pixValid, markOut, pixOut}, {2'b10, 8'h00});
  endtask

  task automatic testCursor();
    setCursor(6'd63, 5'd7);
    present(1, 0, 8'h12, 9'h074, 6'd63);
    check("R7 cursor cell inverted", {pixValid, markOut, pixOut}, {2'b11, ~fontOf(7'h12, 4'h4)});
    present(1, 0, 8'h12, 9'h074, 6'd62);
    check("R7 neighbour column untouched", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h12, 4'h4)});
    present(1, 0, 8'h12, 9'h084, 6'd63);
    check("R7 next row untouched", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h12, 4'h4)});
    present(1, 0, 8'h92, 9'h07C, 6'd63);
    check("R8 cursor XOR inverse", {pixValid, markOut, pixOut}, {2'b10, fontOf(7'h12, 4'hC)});
    present(0, 0, 8'h92, 9'h07C, 6'd63);
    check("R3 cursor ignored in pass-through", {pixValid, markOut, pixOut}, {2'b10, 8'h92});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset_pre: begin
      check("R1 outputs held in reset", {pixValid, markOut, pixOut}, 10'h0);
    end
    rstN = 1;
    testReset();
    testIdle();
    testPass();
    testGlyph();
    testInverse();
    testRows();
    testCursor();
    testIdle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule